// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the device side of a small serial memory of 128 bytes. It sits on three wires: a serial clock, a data line and an enable line, with the data line split into an input, an output and an output enable. While the enable line is high, the host shifts a command frame in on the rising serial-clock edges. The frame is a data byte sent least significant bit first, then a 7-bit byte address, also least significant bit first, and then one control bit. Only the most recent 24 received bits are kept.

The operation is chosen when the enable line falls. A control bit of 0 starts a read. The block then presents one bit per falling serial-clock edge, most significant bit first, and moves on to the next address after each byte. A control bit of 1 starts a write when the data line is low at that moment, and an erase when it is high. Both take a fixed number of system clocks, signalled on `busy`. Raising the enable line before the count ends abandons the operation. A frame that is too short for the chosen operation is rejected and raises `cmdError`.

All serial inputs are sampled by the system clock `clk`. They are assumed to be synchronous to it, and each serial phase is held for at least two system clocks.

Top module: `wire3_eeprom`

## Requirements
- R1: After reset `serDataOe`, `busy` and `cmdError` are 0, and every byte of storage reads as 0xFF.
- R2: A command bit is taken from `serDataIn` at each rising `serClk` edge while `enLine` is high. The bits are sent in this order: data bits 0..7, address bits 0..6, control bit. Any earlier bits beyond the newest 24 have no effect.
- R3: When `enLine` falls with control bit 0 and at least 8 bits received since `enLine` last rose, a read of the addressed byte starts and `serDataOe` goes to 1 within 2 clocks.
- R4: During a read, each falling `serClk` edge drives the next bit of the current byte, most significant bit first, on `serDataOut` within 2 clocks. After the 8th bit the address advances by one, wrapping from 127 to 0.
- R5: When `enLine` falls with control bit 1, `serDataIn` low and at least 16 bits received, the data byte is stored at the address.
- R6: When `enLine` falls with control bit 1, `serDataIn` high and at least 8 bits received, the addressed byte becomes 0xFF.
- R7: A write or erase holds `busy` high for BUSY_CYCLES clocks and updates storage when that count ends. If `enLine` rises first, the operation is dropped and storage is unchanged.
- R8: `serDataOe` is 0 outside a read and returns to 0 within 2 clocks of `enLine` rising.
- R9: A frame with too few bits (8 for read or erase, 16 for write) starts nothing. It leaves storage unchanged and sets `cmdError` from the fall of `enLine` until `enLine` rises.
- R10: Each new read restarts at the most significant bit of its address, even when the previous read ended part-way through a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock from the host |
| serDataIn | input | 1 | Data line as driven by the host |
| enLine | input | 1 | Enable line: high = command entry, low = operation |
| serDataOut | output | 1 | Data line value driven during a read |
| serDataOe | output | 1 | Output enable for the data line |
| busy | output | 1 | Write or erase in progress |
| cmdError | output | 1 | Last frame was too short |

## Verification
Storage is first read back from address 0 through all 128 bytes to show the erased state. It is then written at every address with an arithmetic pattern and read back in one long read, so that address decoding, bit order and address advance are checked over the whole array. An erase of every third address, read back the same way, separates erase from write by the level on the data line. Separate runs cover the wrap from 127 to 0, a frame preceded by extra bits, frames cut short for read and for write, a write abandoned while busy, and a read interrupted mid-byte and then restarted.

// File: rtl/wire3_eeprom_pkg.sv
package wire3_eeprom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_PROG,
    ST_HOLD
  } mode_e;

  typedef struct packed {
    logic shiftEn;
    logic bitVal;
    logic loadRdAddr;
    logic outStep;
    logic commitWrite;
    logic commitErase;
  } strobe_t;

endpackage

// File: rtl/wire3_eeprom_ctrl.sv
module wire3_eeprom_ctrl
  import wire3_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serDataIn,
  input  logic    enLine,
  input  logic    ctrlBit,
  output strobe_t strb,
  output logic    busy,
  output logic    cmdError,
  output logic    serDataOe
);

  localparam int READ_MIN  = ADDR_W + 1;
  localparam int WRITE_MIN = ADDR_W + DATA_W + 1;
  localparam int CNT_W     = $clog2(WRITE_MIN + 1);
  localparam int BSY_W     = $clog2(BUSY_CYCLES + 1);

  logic sClkQ, sClkPrev, enQ, enPrev, dinQ;
  logic sRise, sFall, enRise, enFall;
  logic [CNT_W-1:0] cmdCount;
  logic [BSY_W-1:0] busyCnt;
  logic okRead, okWrite, opIsWrite, progDone;
  mode_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sClkQ <= 1'b0; sClkPrev <= 1'b0;
      enQ <= 1'b0; enPrev <= 1'b0; dinQ <= 1'b0;
    end else begin
      sClkQ <= serClk; sClkPrev <= sClkQ;
      enQ <= enLine; enPrev <= enQ; dinQ <= serDataIn;
    end
  end

  assign sRise  = sClkQ & ~sClkPrev;
  assign sFall  = ~sClkQ & sClkPrev;
  assign enRise = enQ & ~enPrev;
  assign enFall = ~enQ & enPrev;
  assign okRead  = cmdCount >= CNT_W'(READ_MIN);
  assign okWrite = cmdCount >= CNT_W'(WRITE_MIN);
  assign progDone = (state == ST_PROG) && (busyCnt == '0) && !enRise;

  always_comb begin
    strb = '0;
    strb.shiftEn     = sRise & enQ;
    strb.bitVal      = dinQ;
    strb.loadRdAddr  = enFall && (state == ST_IDLE) && !ctrlBit && okRead;
    strb.outStep     = sFall && (state == ST_READ);
    strb.commitWrite = progDone && opIsWrite;
    strb.commitErase = progDone && !opIsWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCount <= '0;
    end else if (enRise) begin
      cmdCount <= '0;
    end else if (strb.shiftEn && !okWrite) begin
      cmdCount <= cmdCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; busyCnt <= '0; opIsWrite <= 1'b0; cmdError <= 1'b0;
    end else if (enRise) begin
      state <= ST_IDLE; cmdError <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (enFall) begin
          if (!ctrlBit) begin
            if (okRead) state <= ST_READ;
            else cmdError <= 1'b1;
          end else if (dinQ ? okRead : okWrite) begin
            state     <= ST_PROG;
            busyCnt   <= BSY_W'(BUSY_CYCLES - 1);
            opIsWrite <= !dinQ;
          end else begin
            cmdError <= 1'b1;
          end
        end
        ST_PROG: if (busyCnt == '0) state <= ST_HOLD;
                 else busyCnt <= busyCnt - 1'b1;
        default: state <= state;
      endcase
    end
  end

  assign busy      = (state == ST_PROG);
  assign serDataOe = (state == ST_READ);

  // R8
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    enRise |=> !serDataOe);
  // R7
  commit_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWrite || strb.commitErase) |=> !busy);
  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> !busy && !serDataOe);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdCount <= CNT_W'(WRITE_MIN));

endmodule

// File: rtl/wire3_eeprom_dp.sv
module wire3_eeprom_dp
  import wire3_eeprom_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int HIST_W = 24
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  output logic    ctrlBit,
  output logic    serDataOut
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int BIT_W = $clog2(DATA_W);

  logic [HIST_W-1:0] shiftReg;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] cmdAddr, rdAddr;
  logic [DATA_W-1:0] cmdData, rdByte;
  logic [BIT_W-1:0]  bitIdx;
  logic              outBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {strb.bitVal, shiftReg[HIST_W-1:1]};
  end

  assign ctrlBit = shiftReg[HIST_W-1];
  assign cmdAddr = shiftReg[HIST_W-2 -: ADDR_W];
  assign cmdData = shiftReg[HIST_W-2-ADDR_W -: DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.commitWrite) begin
      mem[cmdAddr] <= cmdData;
    end else if (strb.commitErase) begin
      mem[cmdAddr] <= '1;
    end
  end

  assign rdByte = mem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0; bitIdx <= '0; outBit <= 1'b0;
    end else if (strb.loadRdAddr) begin
      rdAddr <= cmdAddr; bitIdx <= '0; outBit <= 1'b0;
    end else if (strb.outStep) begin
      outBit <= rdByte[BIT_W'(DATA_W - 1) - bitIdx];
      if (bitIdx == BIT_W'(DATA_W - 1)) begin
        bitIdx <= '0;
        rdAddr <= rdAddr + 1'b1;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  assign serDataOut = outBit;

  // R4
  rdaddr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.outStep && bitIdx != BIT_W'(DATA_W - 1) && !strb.loadRdAddr) |=> $stable(rdAddr));
  // R4
  rdaddr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.outStep && bitIdx == BIT_W'(DATA_W - 1) && !strb.loadRdAddr) |=> rdAddr == $past(rdAddr) + 1'b1);

endmodule

// File: rtl/wire3_eeprom.sv
module wire3_eeprom
  import wire3_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int HIST_W      = 24,
  parameter int BUSY_CYCLES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic serDataIn,
  input  logic enLine,
  output logic serDataOut,
  output logic serDataOe,
  output logic busy,
  output logic cmdError
);

  strobe_t strb;
  logic    ctrlBit;

  wire3_eeprom_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDataIn(serDataIn),
    .enLine(enLine), .ctrlBit(ctrlBit), .strb(strb), .busy(busy),
    .cmdError(cmdError), .serDataOe(serDataOe)
  );

  wire3_eeprom_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HIST_W(HIST_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlBit(ctrlBit), .serDataOut(serDataOut)
  );

endmodule

// File: tb/wire3_eeprom_bench.sv
module wire3_eeprom_bench;

  localparam int BUSY = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serDataIn = 1'b0, enLine = 1'b0;
  logic serDataOut, serDataOe, busy, cmdError;
  int testCount = 0, failCount = 0;
  logic [7:0] model [128];

  always #5 clk = ~clk;

  wire3_eeprom #(.BUSY_CYCLES(BUSY)) u_wire3_eeprom (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDataIn(serDataIn), .enLine(enLine),
    .serDataOut(serDataOut), .serDataOe(serDataOe), .busy(busy), .cmdError(cmdError)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    serDataIn = b; waitN(2);
    serClk = 1'b1; waitN(3);
    serClk = 1'b0; waitN(2);
  endtask

  // bit i of seq is the i-th bit on the wire: data[0..7], addr[0..6], ctrl
  task automatic sendFrame(input logic ctrl, input logic [6:0] a, input logic [7:0] d, input int nBits);
    logic [15:0] seq = {ctrl, a, d};
    for (int i = 16 - nBits; i < 16; i++) sendBit(seq[i]);
  endtask

  task automatic dropEnable(input logic lvl);
    serDataIn = lvl; waitN(2);
    enLine = 1'b0;
  endtask

  task automatic raiseEnable();
    enLine = 1'b1; waitN(4);
  endtask

  task automatic progOp(input logic isErase, input logic [6:0] a, input logic [7:0] d, input int junk);
    for (int j = 0; j < junk; j++) sendBit(1'b1);
    sendFrame(1'b1, a, d, 16);
    dropEnable(isErase);
    waitN(3);
    chk(busy == 1'b1, "R7 busy high", busy, 1);
    chk(serDataOe == 1'b0, "R8 oe low while busy", serDataOe, 0);
    waitN(BUSY + 3);
    chk(busy == 1'b0, "R7 busy ends", busy, 0);
    raiseEnable();
    model[a] = isErase ? 8'hFF : d;
  endtask

  task automatic startRead(input logic [6:0] a);
    sendFrame(1'b0, a, 8'h00, 8);
    dropEnable(1'b0);
    waitN(3);
    chk(serDataOe == 1'b1, "R3 oe on read", serDataOe, 1);
  endtask

  task automatic readByte(output logic [7:0] r);
    r = '0;
    for (int i = 0; i < 8; i++) begin
      serClk = 1'b1; waitN(3);
      serClk = 1'b0; waitN(4);
      r = {r[6:0], serDataOut};
    end
  endtask

  task automatic endRead();
    enLine = 1'b1; waitN(2);
    chk(serDataOe == 1'b0, "R8 oe released", serDataOe, 0);
    waitN(2);
  endtask

  task automatic sweep(input string tag);
    logic [7:0] r;
    startRead(7'd0);
    for (int a = 0; a < 128; a++) begin
      readByte(r);
      chk(r == model[a], tag, r, model[a]);
    end
    endRead();
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin @(posedge clk); wd++; end
    failCount++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", wd, 190000);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [7:0] r;
    for (int a = 0; a < 128; a++) model[a] = 8'hFF;
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    chk(serDataOe == 1'b0, "R1 oe reset", serDataOe, 0);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(cmdError == 1'b0, "R1 error reset", cmdError, 0);
    raiseEnable();

    sweep("R1 erased contents");

    for (int a = 0; a < 128; a++) progOp(1'b0, 7'(a), 8'((a * 37 + 11) & 8'hFF), 0);
    sweep("R5 write sweep");

    // R4 wrap from 127 to 0
    startRead(7'd126);
    for (int k = 0; k < 4; k++) begin
      readByte(r);
      chk(r == model[(126 + k) % 128], "R4 address wrap", r, model[(126 + k) % 128]);
    end
    endRead();

    for (int a = 0; a < 128; a += 3) progOp(1'b1, 7'(a), 8'h00, 0);
    sweep("R6 erase sweep");

    // R7 abandoned write
    sendFrame(1'b1, 7'd5, 8'h5A, 16);
    dropEnable(1'b0);
    waitN(4);
    chk(busy == 1'b1, "R7 busy before abort", busy, 1);
    raiseEnable();
    chk(busy == 1'b0, "R7 busy after abort", busy, 0);
    startRead(7'd5); readByte(r); endRead();
    chk(r == model[5], "R7 abort keeps data", r, model[5]);

    // R9 short read frame
    sendFrame(1'b0, 7'd3, 8'h00, 5);
    dropEnable(1'b0);
    waitN(4);
    chk(cmdError == 1'b1, "R9 short read error", cmdError, 1);
    chk(serDataOe == 1'b0, "R9 short read no oe", serDataOe, 0);
    raiseEnable();
    chk(cmdError == 1'b0, "R9 error cleared", cmdError, 0);

    // R9 short write frame
    sendFrame(1'b1, 7'd9, 8'h00, 12);
    dropEnable(1'b0);
    waitN(4);
    chk(cmdError == 1'b1, "R9 short write error", cmdError, 1);
    chk(busy == 1'b0, "R9 short write no busy", busy, 0);
    raiseEnable();
    startRead(7'd9); readByte(r); endRead();
    chk(r == model[9], "R9 short write keeps data", r, model[9]);

    // R2 leading extra bits beyond history
    progOp(1'b0, 7'd40, 8'hC3, 9);
    startRead(7'd40); readByte(r); endRead();
    chk(r == 8'hC3, "R2 extra leading bits", r, 8'hC3);

    // R10 restart after partial byte
    progOp(1'b0, 7'd20, 8'hA5, 0);
    startRead(7'd20);
    for (int i = 0; i < 3; i++) begin
      serClk = 1'b1; waitN(3); serClk = 1'b0; waitN(4);
    end
    endRead();
    startRead(7'd20); readByte(r); endRead();
    chk(r == 8'hA5, "R10 restart at MSB", r, 8'hA5);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule